// File: doc/BRIEF.md
# Grid Fire-Request Event Arbiter

This block gathers the pending fire flags of a square grid of integrate-and-fire cells and sends them out one by one as address events on a request/acknowledge port. It chooses in two levels. First, each row's flags are ORed together and a fixed-priority encoder picks the winning row. Next, that row's flag vector is routed through a multiplexer to a second fixed-priority encoder, which picks the column. The resulting row and column indices form the output event address.

When the downstream receiver acknowledges an event, the block sends a single-cycle clear strobe to the flag of the cell it has just served. The upstream side marks an incoming event as under service by holding a busy line. The block returns the input acknowledge only after every fired cell has been emitted. Because no new input event can arrive while flags are still being drained, fixed priority cannot starve any cell.

Top module: `grid_event_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_req_o`, `in_ack_o` and every bit of `cell_clr_o` are low.
- R2: Of all rows with at least one pending flag, the event issued is for the one with the lowest index.
- R3: Inside the chosen row, the pending flag with the lowest column index is issued.
- R4: The flag of the cell at row r, column c is `cell_req_i[r*GRID_N + c]`, and its event shows `out_row_o = r` and `out_col_o = c`.
- R5: After `out_req_o` rises, it stays high with an unchanged address until `out_ack_i` is sampled high. This holds even if flags of higher priority appear in the meantime.
- R6: In any cycle where `out_req_o` and `out_ack_i` are both high, `cell_clr_o` shows exactly the bit of the served cell. `out_req_o` is low one cycle later, and so is `cell_clr_o`.
- R7: After an acknowledge, no new event is raised while `out_ack_i` stays high (four-phase handshake).
- R8: `in_ack_o` rises one cycle after a cycle in which `evt_busy_i` is high, no flag is pending and no event is in flight. It stays low while any flag is pending.
- R9: `in_ack_o` goes low one cycle after `evt_busy_i` falls.
- R10: If a flag is pending while the block is idle, `out_req_o` is high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_req_i | input | GRID_N*GRID_N | Pending fire flags, row-major |
| evt_busy_i | input | 1 | An input event is under service |
| out_ack_i | input | 1 | Output event acknowledge |
| out_req_o | output | 1 | Output event request |
| out_row_o | output | $clog2(GRID_N) | Output event row address |
| out_col_o | output | $clog2(GRID_N) | Output event column address |
| cell_clr_o | output | GRID_N*GRID_N | One-hot clear strobe for the served flag |
| in_ack_o | output | 1 | Acknowledge back to the input emitter |

## Verification
If the latched address or the handshake state were corrupted, the first wrong event address would appear on `out_row_o`/`out_col_o`. It would show at the next rising edge of `out_req_o`, and the clear strobe of that same cycle would point at the wrong flag. The mistake then spreads: a flag that should have been cleared is issued again, and the drain order stops following lowest index first. A bad completion condition shows up as `in_ack_o` rising while flags are still set, or rising more than one cycle after the grid becomes empty. Each drained pattern is compared against the order given by lowest row-major index.

// File: rtl/grid_evarb_pkg.sv
package grid_evarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } hs_state_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/grid_evarb_prio.sv
module grid_evarb_prio #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IW = grid_evarb_pkg::idx_w(WIDTH)
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o
);

  // lowest index wins
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  always_comb begin
    if (!$isunknown(req_i) && valid_o) begin
      p_pick_set_r2 : assert (req_i[idx_o]);
      for (int j = 0; j < int'(WIDTH); j++) begin
        if (j < int'(idx_o)) begin
          p_lower_empty_r3 : assert (!req_i[j]);
        end
      end
    end
  end

endmodule

// File: rtl/grid_evarb_row_sel.sv
module grid_evarb_row_sel #(
  parameter int unsigned GRID_N = 8,
  localparam int unsigned AW = grid_evarb_pkg::idx_w(GRID_N),
  localparam int unsigned CELLS = GRID_N * GRID_N
) (
  input  logic [CELLS-1:0]  req_i,
  input  logic [AW-1:0]     sel_i,
  output logic [GRID_N-1:0] row_any_o,
  output logic [GRID_N-1:0] row_vec_o
);

  logic [GRID_N-1:0] rows [GRID_N];

  for (genvar r = 0; r < GRID_N; r++) begin : g_row
    assign rows[r]      = req_i[r*GRID_N +: GRID_N];
    assign row_any_o[r] = |rows[r];
  end

  always_comb begin
    row_vec_o = '0;
    for (int r = 0; r < int'(GRID_N); r++) begin
      if (sel_i == AW'(r)) row_vec_o = rows[r];
    end
  end

endmodule

// File: rtl/grid_evarb_hs.sv
module grid_evarb_hs #(
  parameter int unsigned GRID_N = 8,
  localparam int unsigned AW = grid_evarb_pkg::idx_w(GRID_N),
  localparam int unsigned CELLS = GRID_N * GRID_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_i,
  input  logic [AW-1:0]    row_i,
  input  logic [AW-1:0]    col_i,
  input  logic             evt_busy_i,
  input  logic             out_ack_i,
  output logic             out_req_o,
  output logic [AW-1:0]    out_row_o,
  output logic [AW-1:0]    out_col_o,
  output logic [CELLS-1:0] clr_o,
  output logic             in_ack_o
);
  import grid_evarb_pkg::*;

  hs_state_e   state_q, state_d;
  logic [AW-1:0] row_q, col_q;
  logic        in_ack_q;
  logic        clr_fire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pend_i)     state_d = ST_SEND;
      ST_SEND: if (out_ack_i)  state_d = ST_WAIT;
      ST_WAIT: if (!out_ack_i) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      in_ack_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (state_q == ST_IDLE && pend_i) begin
        row_q <= row_i;
        col_q <= col_i;
      end
      in_ack_q <= evt_busy_i && !pend_i && (state_q == ST_IDLE);
    end
  end

  assign out_req_o = (state_q == ST_SEND);
  assign out_row_o = row_q;
  assign out_col_o = col_q;
  assign in_ack_o  = in_ack_q;
  assign clr_fire  = out_req_o && out_ack_i;

  for (genvar r = 0; r < GRID_N; r++) begin : g_clr_r
    for (genvar c = 0; c < GRID_N; c++) begin : g_clr_c
      assign clr_o[r*GRID_N+c] = clr_fire && (row_q == AW'(r)) && (col_q == AW'(c));
    end
  end

  p_hold_addr_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && !out_ack_i) |=> (out_req_o && $stable(out_row_o) && $stable(out_col_o)));

  p_drop_after_ack_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && out_ack_i) |=> !out_req_o);

  p_clr_onehot_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

  p_no_req_under_ack_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> !$past(out_ack_i));

  p_inack_quiet_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> !out_req_o);

  p_inack_follows_busy_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_busy_i |=> !in_ack_o);

endmodule

// File: rtl/grid_event_arbiter.sv
module grid_event_arbiter #(
  parameter int unsigned GRID_N = 8,
  localparam int unsigned AW = grid_evarb_pkg::idx_w(GRID_N),
  localparam int unsigned CELLS = GRID_N * GRID_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CELLS-1:0] cell_req_i,
  input  logic             evt_busy_i,
  input  logic             out_ack_i,
  output logic             out_req_o,
  output logic [AW-1:0]    out_row_o,
  output logic [AW-1:0]    out_col_o,
  output logic [CELLS-1:0] cell_clr_o,
  output logic             in_ack_o
);

  logic [GRID_N-1:0] row_any, row_vec;
  logic [AW-1:0]     row_idx, col_idx;
  logic              row_valid, col_valid;

  grid_evarb_prio #(.WIDTH(GRID_N)) u_row_prio (
    .req_i   (row_any),
    .valid_o (row_valid),
    .idx_o   (row_idx)
  );

  grid_evarb_row_sel #(.GRID_N(GRID_N)) u_row_sel (
    .req_i     (cell_req_i),
    .sel_i     (row_idx),
    .row_any_o (row_any),
    .row_vec_o (row_vec)
  );

  grid_evarb_prio #(.WIDTH(GRID_N)) u_col_prio (
    .req_i   (row_vec),
    .valid_o (col_valid),
    .idx_o   (col_idx)
  );

  grid_evarb_hs #(.GRID_N(GRID_N)) u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (row_valid && col_valid),
    .row_i      (row_idx),
    .col_i      (col_idx),
    .evt_busy_i (evt_busy_i),
    .out_ack_i  (out_ack_i),
    .out_req_o  (out_req_o),
    .out_row_o  (out_row_o),
    .out_col_o  (out_col_o),
    .clr_o      (cell_clr_o),
    .in_ack_o   (in_ack_o)
  );

endmodule

// File: tb/grid_event_arbiter_bench.sv
module grid_event_arbiter_bench;
  localparam int N = 8;
  localparam int CELLS = N * N;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CELLS-1:0] flags = '0;
  logic evt_busy = 1'b0;
  logic out_ack = 1'b0;
  logic out_req, in_ack;
  logic [2:0] out_row, out_col;
  logic [CELLS-1:0] clr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  grid_event_arbiter #(.GRID_N(N)) u_grid_event_arbiter (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cell_req_i (flags),
    .evt_busy_i (evt_busy),
    .out_ack_i  (out_ack),
    .out_req_o  (out_req),
    .out_row_o  (out_row),
    .out_col_o  (out_col),
    .cell_clr_o (clr),
    .in_ack_o   (in_ack)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [CELLS-1:0] v);
    for (int i = 0; i < CELLS; i++) if (v[i]) return i;
    return -1;
  endfunction

  // serve the next event; optionally inject a higher-priority flag during hold
  task automatic serve_next(input int hold, input int inject);
    int exp_i;
    int lim;
    logic [2:0] r0, c0;
    exp_i = lowest(flags);
    lim = 0;
    while (!out_req && lim < 20) begin
      @(negedge clk);
      lim++;
    end
    chk(out_req, "R10 out_req not raised", out_req, 1);
    chk(out_row == 3'(exp_i / N), "R2 R4 row", out_row, exp_i / N);
    chk(out_col == 3'(exp_i % N), "R3 R4 col", out_col, exp_i % N);
    r0 = out_row;
    c0 = out_col;
    for (int h = 0; h < hold; h++) begin
      if (h == 0 && inject >= 0) flags[inject] = 1'b1;
      @(negedge clk);
      chk(out_req && out_row == r0 && out_col == c0, "R5 hold",
          {out_req, out_row, out_col}, {1'b1, r0, c0});
    end
    out_ack = 1'b1;
    #1;
    chk(clr == (CELLS'(1) << exp_i), "R6 clear strobe", clr, CELLS'(1) << exp_i);
    @(negedge clk);
    chk(!out_req && clr == '0, "R6 after ack", {out_req, clr}, 0);
    flags[exp_i] = 1'b0;
    for (int w = 0; w < 2; w++) begin
      @(negedge clk);
      chk(!out_req, "R7 no req under ack", out_req, 0);
    end
    out_ack = 1'b0;
  endtask

  task automatic drain_and_ack();
    while (flags != '0) begin
      chk(!in_ack, "R8 in_ack while pending", in_ack, 0);
      serve_next(1, -1);
    end
    @(negedge clk);
    chk(!in_ack, "R8 in_ack early", in_ack, 0);
    @(negedge clk);
    chk(in_ack, "R8 in_ack after drain", in_ack, 1);
  endtask

  task automatic release_event();
    evt_busy = 1'b0;
    @(negedge clk);
    chk(!in_ack, "R9 in_ack drop", in_ack, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(!out_req && !in_ack && clr == '0, "R1 in reset", {out_req, in_ack, clr}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_req && !in_ack && clr == '0, "R1 after reset", {out_req, in_ack, clr}, 0);
  endtask

  task automatic t_single();
    flags[2*N+5] = 1'b1;
    evt_busy = 1'b1;
    @(negedge clk);
    chk(out_req, "R10 one edge latency", out_req, 1);
    chk(!in_ack, "R8 pending blocks ack", in_ack, 0);
    serve_next(3, -1);
    drain_and_ack();
    release_event();
  endtask

  task automatic t_rows();
    flags[5*N+0] = 1'b1;
    flags[1*N+6] = 1'b1;
    flags[1*N+2] = 1'b1;
    flags[6*N+3] = 1'b1;
    evt_busy = 1'b1;
    drain_and_ack();
    release_event();
  endtask

  task automatic t_inject();
    flags[4*N+4] = 1'b1;
    flags[7*N+7] = 1'b1;
    evt_busy = 1'b1;
    serve_next(3, 0);
    drain_and_ack();
    release_event();
  endtask

  task automatic t_pattern(input logic [CELLS-1:0] p);
    flags = p;
    evt_busy = 1'b1;
    drain_and_ack();
    release_event();
  endtask

  initial begin
    t_reset();
    t_single();
    t_rows();
    t_inject();
    t_pattern(64'h8000_0000_0000_0001);
    t_pattern(64'h0102_0408_1020_4080);
    t_pattern(64'hFF00_0000_0000_0000);
    t_pattern(64'h0000_0010_0000_0100);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule